// File: doc/BRIEF.md
# Command-Pointer I2C Register Slave

This block is the serial front end of a small sensor's register file. It watches an I2C-compatible two-wire bus, finds start, repeated start and stop conditions, and answers one 7-bit device address. A 2-bit strap input, already decoded from a three-level pin, picks that address. The block shifts bytes in and out and pulls SDA low for acknowledge. It also keeps a 4-bit register pointer that persists between transactions.

The master writes a byte whose top bit is 1 to load the pointer from that byte's low nibble. Any byte whose top bit is 0 is data. A data byte goes into the register at the pointer. Each further byte in the same bus phase goes to the next address, so a two-byte access moves a low byte and then a high byte. A read phase begins at the stored pointer. It can follow a repeated start, which is the usual combined format, or it can be a read-only transaction of its own. The master ends a read with a not-acknowledge and a stop.

Seven configuration bytes (addresses 0h to 6h) can be written and are exposed on a flat output bus. Address 8h holds a fixed test byte and Ah holds a fixed identity byte. Addresses Ch to Fh return two 16-bit measurement inputs. The remaining addresses read as zero.

Top module: `cmdptr_i2c_slave`

## Requirements
- R1: While reset is asserted and just after it, `sda_oe` is 0 and every bit of `cfg_o` is 0.
- R2: The slave acknowledges only the address set by the strap. `addr_sel` = 0 gives 7'b0101001, 1 gives 7'b0111001, and 2 or 3 gives 7'b1001001. An address byte that does not match gets no acknowledge, and `sda_oe` stays 0 until the next start.
- R3: After a matching address byte, and after every byte written to the slave, SDA is held low through the ninth clock.
- R4: In a write phase, a byte with bit 7 = 1 is a command. It loads bits 3:0 into the pointer and changes no register.
- R5: A byte with bit 7 = 0 is written to the register at the pointer. Register k (k = 0..6) appears on `cfg_o[8k+7:8k]`. `cfg_o` changes only at such a write.
- R6: The n-th data byte of a phase (counting from 0) uses address pointer+n, modulo 16. The stored pointer itself changes only on a command, so the next phase starts again at it.
- R7: A read phase returns register pointer+n as its n-th byte, MSB first. This holds after a repeated start and after a fresh start alike.
- R8: Read values: 8h gives the TEST_VALUE parameter and Ah gives ID_VALUE. Ch/Dh give the low and high bytes of `data0_i`, and Eh/Fh give the low and high bytes of `data1_i`. 7h, 9h and Bh read 00h.
- R9: Data bytes aimed at addresses 7h to Fh are acknowledged and discarded.
- R10: When the master answers a read byte with not-acknowledge, the slave releases SDA and stays silent until the next start.
- R11: A stop returns the slave to idle, and clock pulses that follow without a start are ignored. The slave changes its SDA drive only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_sel | input | 2 | Decoded address strap (0 low, 1 floating, 2/3 high) |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| data0_i | input | 16 | First measurement word |
| data1_i | input | 16 | Second measurement word |
| cfg_o | output | 56 | Configuration registers 0h..6h, byte k at bits 8k+7:8k |

## Verification
The bench goes after the pointer semantics. If a design moved the stored pointer on every data byte, a read-only transaction after a two-byte write would return the wrong register. If it treated a command byte as data, `cfg_o` would be corrupted, and the bench compares `cfg_o` with its model on every clock. Wrong-address bytes, bytes clocked after a stop with no new start, and bytes aimed at read-only or reserved addresses are all sent. A slave that acknowledged or stored them would show up as an unexpected SDA drive or a changed readback. Reads of every special address, and the SDA release after the final not-acknowledge, catch a wrong read map and a slave that keeps driving after the master ends the read.

// File: rtl/cps_pkg.sv
package cps_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK
    } cps_state_e;

    localparam int CPS_NUM_CFG = 7;
    localparam int CPS_CFG_W   = 8 * CPS_NUM_CFG;

    localparam logic [3:0] CPS_A_TEST = 4'h8;
    localparam logic [3:0] CPS_A_ID   = 4'hA;
    localparam logic [3:0] CPS_A_D0L  = 4'hC;
    localparam logic [3:0] CPS_A_D0H  = 4'hD;
    localparam logic [3:0] CPS_A_D1L  = 4'hE;
    localparam logic [3:0] CPS_A_D1H  = 4'hF;

    function automatic logic [6:0] cps_own_addr(input logic [1:0] sel);
        unique case (sel)
            2'd0:    return 7'b0101001;
            2'd1:    return 7'b0111001;
            default: return 7'b1001001;
        endcase
    endfunction

endpackage

// File: rtl/cps_line_sync.sv
module cps_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_q,
    output logic sda_q,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_sh, sda_sh;
    logic              scl_prev, sda_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh   <= '1;
            sda_sh   <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_sh   <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh   <= {sda_sh[STAGES-2:0], sda_i};
            scl_prev <= scl_sh[STAGES-1];
            sda_prev <= sda_sh[STAGES-1];
        end
    end

    assign scl_q     = scl_sh[STAGES-1];
    assign sda_q     = sda_sh[STAGES-1];
    assign scl_rise  = scl_q && !scl_prev;
    assign scl_fall  = !scl_q && scl_prev;
    assign start_det = scl_q && scl_prev && sda_prev && !sda_q;
    assign stop_det  = scl_q && scl_prev && !sda_prev && sda_q;
endmodule

// File: rtl/cps_regfile.sv
module cps_regfile
    import cps_pkg::*;
#(
    parameter logic [7:0] ID_VALUE   = 8'h5C,
    parameter logic [7:0] TEST_VALUE = 8'hA5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [3:0]           wr_addr,
    input  logic [7:0]           wdata,
    input  logic [3:0]           rd_addr,
    input  logic [15:0]          data0_i,
    input  logic [15:0]          data1_i,
    output logic [7:0]           rdata,
    output logic [CPS_CFG_W-1:0] cfg_o
);
    localparam logic [3:0] CFG_LAST = 4'(CPS_NUM_CFG - 1);

    logic [7:0] cfg_q [CPS_NUM_CFG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < CPS_NUM_CFG; i++) cfg_q[i] <= '0;
        end else if (wr_en && (wr_addr <= CFG_LAST)) begin
            cfg_q[wr_addr[2:0]] <= wdata;
        end
    end

    for (genvar g = 0; g < CPS_NUM_CFG; g++) begin : g_cfg_out
        assign cfg_o[8*g +: 8] = cfg_q[g];
    end

    always_comb begin
        rdata = '0;
        if (rd_addr <= CFG_LAST) begin
            rdata = cfg_q[rd_addr[2:0]];
        end else begin
            case (rd_addr)
                CPS_A_TEST: rdata = TEST_VALUE;
                CPS_A_ID:   rdata = ID_VALUE;
                CPS_A_D0L:  rdata = data0_i[7:0];
                CPS_A_D0H:  rdata = data0_i[15:8];
                CPS_A_D1L:  rdata = data1_i[7:0];
                CPS_A_D1H:  rdata = data1_i[15:8];
                default:    rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/cmdptr_i2c_slave.sv
module cmdptr_i2c_slave
    import cps_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] ID_VALUE    = 8'h5C,
    parameter logic [7:0] TEST_VALUE  = 8'hA5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           addr_sel,
    input  logic                 scl_i,
    input  logic                 sda_i,
    output logic                 sda_oe,
    input  logic [15:0]          data0_i,
    input  logic [15:0]          data1_i,
    output logic [CPS_CFG_W-1:0] cfg_o
);
    logic scl_q, sda_q, scl_rise, scl_fall, start_det, stop_det;

    cps_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    cps_state_e state, state_nxt;
    logic [7:0] shreg, txreg;
    logic [3:0] cnt, ptr, off;
    logic       nack;
    logic       wr_en;
    logic [3:0] wr_addr, rd_addr;
    logic [7:0] rdata;
    logic       addr_hit, byte_done;

    assign addr_hit  = (shreg[7:1] == cps_own_addr(addr_sel));
    assign byte_done = scl_fall && (cnt == 4'd8);
    assign wr_addr   = ptr + off;
    assign rd_addr   = ptr + off;
    assign wr_en     = (state == ST_WR_BYTE) && byte_done && !shreg[7];

    cps_regfile #(.ID_VALUE(ID_VALUE), .TEST_VALUE(TEST_VALUE)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wdata(shreg), .rd_addr(rd_addr), .data0_i(data0_i), .data1_i(data1_i),
        .rdata(rdata), .cfg_o(cfg_o)
    );

    // next-state decision
    always_comb begin
        state_nxt = state;
        if (start_det) begin
            state_nxt = ST_ADDR;
        end else if (stop_det) begin
            state_nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     state_nxt = ST_IDLE;
                ST_ADDR:     if (byte_done) state_nxt = addr_hit ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK: if (scl_fall) state_nxt = shreg[0] ? ST_RD_BYTE : ST_WR_BYTE;
                ST_WR_BYTE:  if (byte_done) state_nxt = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall) state_nxt = ST_WR_BYTE;
                ST_RD_BYTE:  if (scl_fall && cnt == 4'd7) state_nxt = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall) state_nxt = nack ? ST_IDLE : ST_RD_BYTE;
                default:     state_nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // byte datapath and pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            txreg <= '0;
            cnt   <= '0;
            ptr   <= '0;
            off   <= '0;
            nack  <= 1'b0;
        end else if (start_det) begin
            cnt <= '0;
            off <= '0;
        end else begin
            unique case (state)
                ST_ADDR, ST_WR_BYTE: begin
                    if (scl_rise && cnt < 4'd8) begin
                        shreg <= {shreg[6:0], sda_q};
                        cnt   <= cnt + 4'd1;
                    end
                    if (state == ST_WR_BYTE && byte_done) begin
                        if (shreg[7]) begin
                            ptr <= shreg[3:0];
                            off <= '0;
                        end else begin
                            off <= off + 4'd1;
                        end
                    end
                end
                ST_ADDR_ACK: if (scl_fall) begin
                    cnt <= '0;
                    if (shreg[0]) txreg <= rdata;
                end
                ST_WR_ACK: if (scl_fall) cnt <= '0;
                ST_RD_BYTE: if (scl_fall) begin
                    if (cnt == 4'd7) begin
                        off <= off + 4'd1;
                    end else begin
                        txreg <= {txreg[6:0], 1'b0};
                        cnt   <= cnt + 4'd1;
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) nack <= sda_q;
                    if (scl_fall) begin
                        txreg <= rdata;
                        cnt   <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_ADDR_ACK, ST_WR_ACK: sda_oe = 1'b1;
            ST_RD_BYTE:             sda_oe = !txreg[7];
            default:                sda_oe = 1'b0;
        endcase
    end
endmodule

// File: rtl/cps_checker.sv
module cps_checker
    import cps_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sda_oe,
    input logic                 scl_q,
    input logic                 stop_det,
    input cps_state_e           state,
    input logic [7:0]           shreg,
    input logic [1:0]           addr_sel,
    input logic                 wr_en,
    input logic [3:0]           wr_addr,
    input logic [CPS_CFG_W-1:0] cfg_o
);
    always @(posedge clk) begin
        if (!rst_n) begin
            assert_released_in_reset_R1: assert (!sda_oe && cfg_o == '0);
        end
    end

    assert_ack_only_on_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR_ACK) |-> (shreg[7:1] == cps_own_addr(addr_sel)));

    assert_cfg_moves_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_o) |-> $past(wr_en));

    assert_readonly_discard_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr > 4'd6) |=> $stable(cfg_o));

    assert_release_on_stop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    assert_drive_moves_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_q);
endmodule

bind cmdptr_i2c_slave cps_checker u_chk (
    .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_q(scl_q), .stop_det(stop_det),
    .state(state), .shreg(shreg), .addr_sel(addr_sel), .wr_en(wr_en),
    .wr_addr(wr_addr), .cfg_o(cfg_o)
);

// File: tb/cmdptr_i2c_slave_tb_top.sv
module cmdptr_i2c_slave_tb_top;
    localparam int          Q    = 10;
    localparam logic [7:0]  IDV  = 8'h61;
    localparam logic [7:0]  TSTV = 8'hA3;
    localparam logic [15:0] D0   = 16'hBE0F;
    localparam logic [15:0] D1   = 16'h7C42;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n;
    logic [1:0]  strap;
    logic        scl, sda_m;
    logic        sda_line;
    logic        sda_oe;
    logic [55:0] cfg;

    assign sda_line = sda_m & ~sda_oe;

    cmdptr_i2c_slave #(.SYNC_STAGES(2), .ID_VALUE(IDV), .TEST_VALUE(TSTV)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr_sel(strap), .scl_i(scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .data0_i(D0), .data1_i(D1), .cfg_o(cfg)
    );

    int n_chk = 0, n_bad = 0, mirror_err = 0, drv_seen = 0;
    bit hold = 1'b0, watch = 1'b0;
    logic [7:0]  mreg [16];
    logic [3:0]  mptr, moff;
    logic [55:0] mcfg;

    always_comb begin
        for (int k = 0; k < 7; k++) mcfg[8*k +: 8] = mreg[k];
    end

    always @(negedge clk) begin
        if (rst_n && !hold && cfg !== mcfg) mirror_err++;
        if (watch && sda_oe) drv_seen++;
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [6:0] bus_addr(input logic [1:0] s);
        case (s)
            2'd0:    return 7'h29;
            2'd1:    return 7'h39;
            default: return 7'h49;
        endcase
    endfunction

    function automatic logic [7:0] exp_rd(input logic [3:0] a);
        case (a)
            4'h8:    return TSTV;
            4'hA:    return IDV;
            4'hC:    return D0[7:0];
            4'hD:    return D0[15:8];
            4'hE:    return D1[7:0];
            4'hF:    return D1[15:8];
            default: return (a < 4'h7) ? mreg[a] : 8'h00;
        endcase
    endfunction

    task automatic hw(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl = 1'b1; hw(Q);
        sda_m = 1'b0; hw(Q);
        scl = 1'b0; hw(Q);
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; hw(Q);
        scl = 1'b1; hw(Q);
        sda_m = 1'b0; hw(Q);
        scl = 1'b0; hw(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hw(Q);
        scl = 1'b1; hw(Q);
        sda_m = 1'b1; hw(Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; hw(Q);
        scl = 1'b1; hw(Q);
        scl = 1'b0; hw(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; hw(Q);
        scl = 1'b1; hw(Q / 2);
        ack = !sda_line;
        hw(Q / 2);
        scl = 1'b0; hw(Q);
    endtask

    task automatic recv_byte(input bit last, output logic [7:0] b);
        sda_m = 1'b1;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            hw(Q);
            scl = 1'b1; hw(Q / 2);
            b = {b[6:0], sda_line};
            hw(Q / 2);
            scl = 1'b0;
        end
        hw(Q / 2);
        sda_m = last;
        hw(Q / 2);
        scl = 1'b1; hw(Q);
        scl = 1'b0; hw(Q / 2);
        sda_m = 1'b1; hw(Q / 2);
    endtask

    task automatic begin_phase(input bit rd, input bit rep);
        bit ack;
        if (rep) bus_rstart(); else bus_start();
        send_byte({bus_addr(strap), rd}, ack);
        chk(ack, "R3 address ack", ack, 1);
        moff = '0;
    endtask

    task automatic wbyte(input logic [7:0] b);
        bit ack;
        hold = 1'b1;
        send_byte(b, ack);
        chk(ack, b[7] ? "R3 ack command R4" : "R3 ack data R5", ack, 1);
        if (b[7]) begin
            mptr = b[3:0];
            moff = '0;
        end else begin
            if ((mptr + moff) < 4'h7) mreg[mptr + moff] = b;
            moff = moff + 4'd1;
        end
        hold = 1'b0;
    endtask

    task automatic rbyte(input bit last, input string tag);
        logic [7:0] b, e;
        e = exp_rd(mptr + moff);
        recv_byte(last, b);
        chk(b == e, tag, b, e);
        moff = moff + 4'd1;
        if (last) begin
            hw(Q);
            chk(!sda_oe, "R10 released after nack", sda_oe, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        bit ack;
        rst_n = 1'b0; scl = 1'b1; sda_m = 1'b1; strap = 2'd0;
        mptr = '0; moff = '0;
        for (int i = 0; i < 16; i++) mreg[i] = '0;
        hw(5);
        chk(!sda_oe && cfg == '0, "R1 reset state", {sda_oe, cfg}, 0);
        rst_n = 1'b1;
        hw(5);
        chk(!sda_oe && cfg == '0, "R1 after reset", {sda_oe, cfg}, 0);

        // R5 single-byte write, R4 command then data
        begin_phase(0, 0); wbyte(8'h81); wbyte(8'h5A); bus_stop();
        chk(cfg[15:8] == 8'h5A, "R5 cfg byte1", cfg[15:8], 8'h5A);
        begin_phase(0, 0); wbyte(8'h85); wbyte(8'h3C); bus_stop();
        // R4 command-only transaction moves pointer, read-only phase follows
        begin_phase(0, 0); wbyte(8'h81); bus_stop();
        begin_phase(1, 0); rbyte(1, "R4 pointer from command R7"); bus_stop();

        // R6 word write, then read-only word read from the unchanged pointer
        begin_phase(0, 0); wbyte(8'h82); wbyte(8'h34); wbyte(8'h12); bus_stop();
        chk(cfg[31:16] == 16'h1234, "R6 word write", cfg[31:16], 16'h1234);
        begin_phase(1, 0); rbyte(0, "R6 low byte at pointer"); rbyte(1, "R6 high byte at pointer+1"); bus_stop();

        // R7 combined format read
        begin_phase(0, 0); wbyte(8'h86); wbyte(8'h6E);
        begin_phase(1, 1); rbyte(0, "R7 combined read reg6"); rbyte(1, "R8 reserved 7 reads zero"); bus_stop();

        // R8 special addresses
        for (int a = 8; a <= 14; a += 2) begin
            begin_phase(0, 0); wbyte(8'h80 | 8'(a));
            begin_phase(1, 1); rbyte(0, "R8 read map even"); rbyte(1, "R8 read map odd"); bus_stop();
        end

        // R9 writes to read-only / reserved addresses
        begin_phase(0, 0); wbyte(8'h8C); wbyte(8'h55); wbyte(8'h66); bus_stop();
        begin_phase(0, 0); wbyte(8'h8A); wbyte(8'h77); bus_stop();
        begin_phase(0, 0); wbyte(8'h87); wbyte(8'h11);
        begin_phase(1, 1); rbyte(1, "R9 reserved 7 unchanged"); bus_stop();
        begin_phase(0, 0); wbyte(8'h8C);
        begin_phase(1, 1); rbyte(0, "R9 data0 low unchanged"); rbyte(1, "R9 data0 high unchanged"); bus_stop();
        begin_phase(0, 0); wbyte(8'h8A);
        begin_phase(1, 1); rbyte(1, "R9 id unchanged"); bus_stop();

        // R2 other straps, including the 3 code
        for (int s = 1; s <= 3; s++) begin
            strap = 2'(s);
            begin_phase(0, 0); wbyte(8'h80); wbyte(8'h10 + 8'(s));
            begin_phase(1, 1); rbyte(1, "R2 strap readback"); bus_stop();
        end

        // R2 mismatched address: no ack, no drive
        strap = 2'd2;
        watch = 1'b1; drv_seen = 0;
        bus_start();
        send_byte({7'h29, 1'b0}, ack);
        chk(!ack, "R2 wrong address not acked", ack, 0);
        send_byte(8'h83, ack);
        chk(!ack, "R2 byte after wrong address", ack, 0);
        bus_stop();
        chk(drv_seen == 0, "R2 no drive on mismatch", drv_seen, 0);

        // R11 stop mid-byte, then a byte with no start
        drv_seen = 0;
        bus_start();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
        bus_stop();
        send_byte({bus_addr(strap), 1'b0}, ack);
        chk(!ack, "R11 no ack without start", ack, 0);
        hw(Q);
        scl = 1'b1; hw(Q);
        chk(drv_seen == 0, "R11 silent after stop", drv_seen, 0);
        watch = 1'b0;

        // pointer unchanged by ignored traffic
        begin_phase(1, 0); rbyte(1, "R11 pointer kept R7"); bus_stop();

        hw(20);
        chk(mirror_err == 0, "R5 cfg mirror every clock", mirror_err, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule